// File: doc/BRIEF.md
# Frame DMA channel arbiter

This block decides which of eight frame DMA channels may move frame data for a two-port CPU frame DMA engine. Channels 0 to 5 are injection channels, and each one is steered to CPU port 0 or port 1 by its own configuration bit. Channel 6 is the extraction channel of port 0 and channel 7 is the extraction channel of port 1. Every channel presents a request, an active flag and an end-of-frame strobe. The arbiter returns a one-hot grant and the port that the granted channel serves.

The two ports share the engine on an equal-bandwidth basis. At every frame boundary the arbiter prefers the port that was not served last. If that port has no eligible channel it is skipped, so an idle port never holds back the busy one. Inside a port, the extraction channel beats any injection channel, and among injection channels the higher number wins. A grant is then held for the whole frame. It is released when the granted channel signals end-of-frame or drops its active flag, and the replacement is chosen at that same clock edge.

The controller has two states. ARB_IDLE means no grant. ARB_HOLD means one channel owns the engine. The transitions are:
- TAKE (ARB_IDLE to ARB_HOLD): an eligible channel exists.
- KEEP (ARB_HOLD to ARB_HOLD): the owner has not finished.
- HANDOVER (ARB_HOLD to ARB_HOLD with a new owner): the owner finishes and another eligible channel exists.
- DRAIN (ARB_HOLD to ARB_IDLE): the owner finishes and nothing is eligible.

Top module: `fdma_chan_arbiter`

## Requirements
- R1: After reset, `grant` is all zero and `grant_port` is 0. The first port preferred after reset is port 0.
- R2: `grant` is always one-hot or zero. When no channel is eligible at a decision point, `grant` is zero in the following cycle and `grant_port` reads 0.
- R3: A channel is eligible only when its `ch_req` and `ch_active` bits are both 1 in the cycle in which the decision is made. A request without the active flag is never granted.
- R4: `grant_port` gives the served port of the granted channel. Channel 6 always serves port 0 and channel 7 always serves port 1. Injection channel i serves port `inj_port_sel[i]` (0 means port 0, 1 means port 1), sampled when the grant is made.
- R5: Within one port, the extraction channel of that port wins over every injection channel assigned to that port.
- R6: Among injection channels assigned to the same port, the channel with the higher number wins.
- R7: At each decision point, the port other than the last-served port is preferred when it has an eligible channel. Two ports that request continuously therefore receive alternating grants.
- R8: When only one port has eligible channels, that port is granted again, even if it was the port served last.
- R9: While a grant is held, it does not change unless the owning channel asserts `ch_eof` or drops `ch_active`. Dropping its `ch_req` and requests from higher-priority channels have no effect.
- R10: A decision is made in the cycle the owner asserts `ch_eof` or drops `ch_active`. The new grant, or zero, appears after the next rising edge.
- R11: `ch_eof` and `ch_active` changes of channels that do not hold the grant do not change the held grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_req | input | 8 | Per-channel request for service |
| ch_active | input | 8 | Per-channel active (enabled) flag |
| ch_eof | input | 8 | Per-channel end-of-frame strobe, last beat of the current frame |
| inj_port_sel | input | 6 | Port assignment of injection channels 0..5 (0 = port 0, 1 = port 1) |
| grant | output | 8 | One-hot grant, zero when no channel owns the engine |
| grant_port | output | 1 | Port served by the granted channel, 0 when no grant |

## Verification
Every result of this block comes from a single register stage. Inputs presented in one cycle decide the grant and port that are visible just after the next rising edge. The bench therefore drives inputs on the falling edge, lets exactly one rising edge pass, and compares on the following falling edge before it drives anything new. A release and its replacement grant are due together, one edge after the cycle that carries the owner's end-of-frame strobe or its dropped active flag. The reference model in the bench advances one step per cycle on that same rule, so random traffic is compared in the same cycle as the directed cases.

// File: rtl/fdma_arb_pkg.sv
package fdma_arb_pkg;

    typedef enum logic [0:0] {
        ARB_IDLE = 1'b0,
        ARB_HOLD = 1'b1
    } arb_state_e;

endpackage

// File: rtl/fdma_port_map.sv
// Splits the eligible channels into per-port candidate sets.
module fdma_port_map #(
    parameter int NUM_INJ = 6,
    localparam int NUM_CH = NUM_INJ + 2
) (
    input  logic [NUM_CH-1:0]  ch_req,
    input  logic [NUM_CH-1:0]  ch_active,
    input  logic [NUM_INJ-1:0] inj_port_sel,
    output logic [NUM_CH-1:0]  cand_p0,
    output logic [NUM_CH-1:0]  cand_p1
);
    localparam int EXT0 = NUM_INJ;
    localparam int EXT1 = NUM_INJ + 1;

    logic [NUM_CH-1:0] elig;
    assign elig = ch_req & ch_active;

    for (genvar i = 0; i < NUM_INJ; i++) begin : g_inj
        assign cand_p0[i] = elig[i] & ~inj_port_sel[i];
        assign cand_p1[i] = elig[i] &  inj_port_sel[i];
    end

    // extraction channels are tied to their own port
    assign cand_p0[EXT0] = elig[EXT0];
    assign cand_p0[EXT1] = 1'b0;
    assign cand_p1[EXT0] = 1'b0;
    assign cand_p1[EXT1] = elig[EXT1];

endmodule

// File: rtl/fdma_prio_pick.sv
// Highest index wins; extraction channels sit above injection channels.
module fdma_prio_pick #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cand,
    output logic [WIDTH-1:0] pick,
    output logic             any
);
    always_comb begin
        pick = '0;
        any  = 1'b0;
        for (int i = 0; i < WIDTH; i++) begin
            if (cand[i]) begin
                pick    = '0;
                pick[i] = 1'b1;
                any     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fdma_chan_arbiter.sv
module fdma_chan_arbiter
    import fdma_arb_pkg::*;
#(
    parameter int NUM_INJ = 6,
    localparam int NUM_CH = NUM_INJ + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_req,
    input  logic [NUM_CH-1:0] ch_active,
    input  logic [NUM_CH-1:0] ch_eof,
    input  logic [NUM_INJ-1:0] inj_port_sel,
    output logic [NUM_CH-1:0] grant,
    output logic              grant_port
);
    localparam int EXT0 = NUM_INJ;
    localparam int EXT1 = NUM_INJ + 1;
    localparam int NUM_PORTS = 2;

    arb_state_e state_q, state_d;
    logic [NUM_CH-1:0] grant_q, grant_d;
    logic              port_q, port_d;
    logic              last_q, last_d;

    logic [NUM_PORTS-1:0][NUM_CH-1:0] cand;
    logic [NUM_PORTS-1:0][NUM_CH-1:0] pick;
    logic [NUM_PORTS-1:0]             any;

    logic [NUM_CH-1:0] cand_p0, cand_p1;

    fdma_port_map #(.NUM_INJ(NUM_INJ)) u_map (
        .ch_req       (ch_req),
        .ch_active    (ch_active),
        .inj_port_sel (inj_port_sel),
        .cand_p0      (cand_p0),
        .cand_p1      (cand_p1)
    );

    assign cand[0] = cand_p0;
    assign cand[1] = cand_p1;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        fdma_prio_pick #(.WIDTH(NUM_CH)) u_pick (
            .cand (cand[p]),
            .pick (pick[p]),
            .any  (any[p])
        );
    end

    // port choice: prefer the port not served last, skip an empty one
    logic              pref_port;
    logic              win_port;
    logic              win_any;
    logic [NUM_CH-1:0] win_grant;

    always_comb begin
        pref_port = ~last_q;
        win_port  = any[pref_port] ? pref_port : ~pref_port;
        win_any   = |any;
        win_grant = pick[win_port];
    end

    // owner finished: last beat seen or channel deactivated
    logic release_w;
    assign release_w = (state_q == ARB_HOLD) &&
                       (((grant_q & ch_eof) != '0) || ((grant_q & ch_active) != grant_q));

    // next-state and output logic
    always_comb begin
        state_d = state_q;
        grant_d = grant_q;
        port_d  = port_q;
        last_d  = last_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (win_any) begin          // TAKE
                    state_d = ARB_HOLD;
                    grant_d = win_grant;
                    port_d  = win_port;
                    last_d  = win_port;
                end
            end
            ARB_HOLD: begin
                if (release_w) begin
                    if (win_any) begin      // HANDOVER
                        grant_d = win_grant;
                        port_d  = win_port;
                        last_d  = win_port;
                    end else begin          // DRAIN
                        state_d = ARB_IDLE;
                        grant_d = '0;
                        port_d  = 1'b0;
                    end
                end                         // else KEEP
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            port_q  <= 1'b0;
            last_q  <= 1'b1;   // so port 0 is preferred first
        end else begin
            grant_q <= grant_d;
            port_q  <= port_d;
            last_q  <= last_d;
        end
    end

    assign grant      = grant_q;
    assign grant_port = port_q;

    // ---------------- assertions ----------------
    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_idle_port_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0) |-> (grant_port == 1'b0));

    assert_new_grant_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && grant != $past(grant)) |-> (($past(ch_req & ch_active) & grant) == grant));

    assert_ext0_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grant[EXT0] |-> (grant_port == 1'b0));

    assert_ext1_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
        grant[EXT1] |-> (grant_port == 1'b1));

    assert_alternate_ports_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_HOLD && release_w && any[~port_q]) |=> (grant_port != $past(grant_port)));

    assert_hold_until_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && (grant & ch_eof) == '0 && (grant & ch_active) == grant)
        |=> (grant == $past(grant)));

    assert_drain_to_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ARB_HOLD && release_w && !(|any)) |=> (grant == '0));

endmodule

// File: tb/fdma_chan_arbiter_tb.sv
module fdma_chan_arbiter_tb;
    localparam int NI = 6;
    localparam int NC = NI + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NC-1:0] ch_req = '0;
    logic [NC-1:0] ch_active = '0;
    logic [NC-1:0] ch_eof = '0;
    logic [NI-1:0] inj_port_sel = '0;
    logic [NC-1:0] grant;
    logic          grant_port;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [NC-1:0] m_grant;
    logic          m_port;
    logic          m_last;
    logic          m_busy;

    always #5 clk = ~clk;

    fdma_chan_arbiter #(.NUM_INJ(NI)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ch_req       (ch_req),
        .ch_active    (ch_active),
        .ch_eof       (ch_eof),
        .inj_port_sel (inj_port_sel),
        .grant        (grant),
        .grant_port   (grant_port)
    );

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic [NC-1:0] r, input logic [NC-1:0] a,
                         input logic [NC-1:0] e, input logic [NI-1:0] s);
        ch_req       = r;
        ch_active    = a;
        ch_eof       = e;
        inj_port_sel = s;
    endtask

    task automatic chk(input string tag, input logic [NC-1:0] exp_g, input logic exp_p);
        checks++;
        if (grant !== exp_g || grant_port !== exp_p) begin
            errors++;
            $display("FAIL %s: actual grant=%h port=%b expected grant=%h port=%b",
                     tag, grant, grant_port, exp_g, exp_p);
        end
    endtask

    // best channel of a port, from the requirements (R4, R5, R6)
    function automatic logic [NC-1:0] best_of(input logic [NC-1:0] el,
                                              input logic [NI-1:0] s, input logic p);
        logic [NC-1:0] r;
        r = '0;
        if (el[NI + int'(p)]) begin
            r[NI + int'(p)] = 1'b1;
        end else begin
            for (int i = NI - 1; i >= 0; i--) begin
                if (r == '0 && el[i] && s[i] == p) r[i] = 1'b1;
            end
        end
        return r;
    endfunction

    task automatic model_reset();
        m_grant = '0; m_port = 1'b0; m_last = 1'b1; m_busy = 1'b0;
    endtask

    // one clock step of the model (R7, R8, R9, R10, R11)
    task automatic model_step();
        logic [NC-1:0] el, bp, bo;
        logic rel, pref;
        el  = ch_req & ch_active;
        rel = m_busy && (((m_grant & ch_eof) != '0) || ((m_grant & ch_active) != m_grant));
        if (!m_busy || rel) begin
            pref = ~m_last;
            bp = best_of(el, inj_port_sel, pref);
            bo = best_of(el, inj_port_sel, ~pref);
            if (bp != '0) begin
                m_grant = bp; m_port = pref; m_last = pref; m_busy = 1'b1;
            end else if (bo != '0) begin
                m_grant = bo; m_port = ~pref; m_last = ~pref; m_busy = 1'b1;
            end else begin
                m_grant = '0; m_port = 1'b0; m_busy = 1'b0;
            end
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        drive('0, '0, '0, '0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        chk("R1 reset state", 8'h00, 1'b0);

        // R2: nothing requested
        drive('0, 8'hFF, '0, '0); cyc();
        chk("R2 no request gives zero grant", 8'h00, 1'b0);

        // R3: request without active
        drive(8'hFF, 8'h00, '0, '0); cyc();
        chk("R3 inactive request ignored", 8'h00, 1'b0);

        // R4: ch6 alone -> port 0
        drive(8'h40, 8'hFF, '0, '0); cyc();
        chk("R4 ch6 on port 0", 8'h40, 1'b0);
        drive(8'h00, 8'hFF, 8'h40, '0); cyc();
        chk("R2 drain after eof", 8'h00, 1'b0);

        // R4: ch7 alone -> port 1
        drive(8'h80, 8'hFF, '0, '0); cyc();
        chk("R4 ch7 on port 1", 8'h80, 1'b1);
        drive(8'h00, 8'hFF, 8'h80, '0); cyc();
        chk("R10 drain", 8'h00, 1'b0);

        // R4: ch2 mapped to port 1
        drive(8'h04, 8'hFF, '0, 6'b000100); cyc();
        chk("R4 injection ch2 on port 1", 8'h04, 1'b1);
        drive(8'h00, 8'hFF, 8'h04, 6'b000100); cyc();
        chk("R10 drain", 8'h00, 1'b0);

        // R5: extraction beats injection on port 0
        drive(8'h60, 8'hFF, '0, '0); cyc();
        chk("R5 ch6 beats ch5", 8'h40, 1'b0);
        drive(8'h00, 8'hFF, 8'h40, '0); cyc();

        // R6: higher injection number wins
        drive(8'h12, 8'hFF, '0, '0); cyc();
        chk("R6 ch4 beats ch1", 8'h10, 1'b0);
        drive(8'h00, 8'hFF, 8'h10, '0); cyc();
        chk("R10 drain", 8'h00, 1'b0);

        // R9 / R11: hold ch1 against higher requests and foreign eof
        drive(8'h02, 8'hFF, '0, '0); cyc();
        chk("R9 ch1 granted", 8'h02, 1'b0);
        drive(8'hE0, 8'hFE, 8'h21, '0); cyc();
        chk("R9 R11 grant held", 8'h02, 1'b0);
        // R10 + R7: release by eof, port 1 preferred after port 0
        drive(8'hE0, 8'hFF, 8'h02, '0); cyc();
        chk("R7 R10 handover to port 1", 8'h80, 1'b1);
        drive(8'hE0, 8'hFF, 8'h00, '0); cyc();
        chk("R9 ch7 held", 8'h80, 1'b1);
        // R10: release by active drop
        drive(8'hE0, 8'h7F, 8'h00, '0); cyc();
        chk("R10 active drop hands over", 8'h40, 1'b0);
        // R8: port 1 empty, port 0 served again
        drive(8'h20, 8'h7F, 8'h40, '0); cyc();
        chk("R8 port 0 served twice", 8'h20, 1'b0);
        drive(8'h00, 8'hFF, 8'h20, '0); cyc();
        chk("R2 drain", 8'h00, 1'b0);

        // R7: continuous requests alternate ports
        drive(8'hC0, 8'hFF, 8'hC0, '0); cyc();
        chk("R7 alternate 1", 8'h80, 1'b1);
        cyc(); chk("R7 alternate 2", 8'h40, 1'b0);
        cyc(); chk("R7 alternate 3", 8'h80, 1'b1);
        cyc(); chk("R7 alternate 4", 8'h40, 1'b0);
        drive(8'h00, 8'hFF, 8'hC0, '0); cyc();
        chk("R2 drain", 8'h00, 1'b0);

        // random traffic against the model
        do_reset();
        chk("R1 reset again", 8'h00, 1'b0);
        for (int n = 0; n < 4000; n++) begin
            logic [NI-1:0] s;
            s = inj_port_sel;
            if (n % 32 == 0) s = NI'($urandom);
            drive(NC'($urandom),
                  ~(NC'($urandom) & NC'($urandom) & NC'($urandom) & NC'($urandom)),
                  NC'($urandom) & NC'($urandom),
                  s);
            model_step();
            cyc();
            chk("R6 R7 R8 R9 R11 random vs model", m_grant, m_port);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule